// File: doc/BRIEF.md
# Comparator-Triggered Pulse Output Shutdown Controller

This block protects an external power stage driven by a timer's pulse generator. It sits between a comparator's digital output and that generator. Software arms it with a trip-enable bit. When the comparator output falls while the block is armed, a single trip event clears several bits together: the trip-enable bit, the pulse-output enable, the timer enable and the partner comparator's trip enable. The output pin returns to general-purpose mode and keeps its last level. A sticky surge interrupt flag is raised.

The comparator signal passes through a synchronizer before the falling edge is detected. A select input can hold the trip back by a programmed count of clocks after the edge. Every enable bit has to be written again before pulses resume. The pulse source is external. A small counter in the bench stands in for it, drives its idle level whenever its timer enable is low, and may idle high or low.

Top module: `pwm_trip_ctrl`

## Requirements
- R1: After reset all four enable bits are 0, the interrupt flag is 0, the pin is in GPIO mode (`pinIsPulse`=0) and `pinOut` is 0.
- R2: A write (`wrEn`=1) loads the enable bits on the next rising edge from `wrData`: bit 0 trip enable, bit 1 pulse-output enable, bit 2 timer enable, bit 3 partner trip enable. `pinIsPulse` equals the pulse-output enable bit, and while it is 1 `pinOut` equals `pulseIn` in the same cycle.
- R3: While the trip enable is 0, a falling edge on `cmpIn` leaves every enable bit and the interrupt flag unchanged.
- R4: With the trip enable set and `delaySel`=0, a falling edge on `cmpIn` takes effect on the third rising clock edge after the input changes. These are two synchronizer stages and one edge register. A rising edge on `cmpIn` never trips.
- R5: A trip clears all four enable bits, including the trip enable, on the same clock edge. A write in the cycle of a trip is overridden by the clear.
- R6: From the trip on, the pin is in GPIO mode. `pinOut` holds the `pulseIn` value sampled at the trip edge and stays at that value while the pin remains in GPIO mode.
- R7: A trip sets `irq`. `irq` stays set until `irqClr` is pulsed (write-1-to-clear). A trip in the same cycle as `irqClr` leaves it set, and a new trip while it is set keeps it set.
- R8: With `delaySel`=1 and `delayLoad`=N (0..15), the trip takes effect on rising edge 3+N after the input falls. Clearing the trip enable while the delay runs cancels the pending trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpIn | input | 1 | Comparator output, asynchronous |
| wrEn | input | 1 | Enable-register write strobe |
| wrData | input | 4 | Enable bits to load (bit map in R2) |
| irqClr | input | 1 | Write-1-to-clear strobe for the interrupt flag |
| delaySel | input | 1 | 1 selects the delayed trip path |
| delayLoad | input | 4 | Delay in clocks for the delayed path |
| pulseIn | input | 1 | Pulse generator output |
| pinOut | output | 1 | Value driven onto the output pin |
| pinIsPulse | output | 1 | Pin mode: 1 pulse output, 0 GPIO |
| armOut | output | 1 | Trip enable bit |
| pulseEnOut | output | 1 | Pulse-output enable bit |
| timerEnOut | output | 1 | Timer enable bit |
| partnerArmOut | output | 1 | Partner comparator trip enable bit |
| irq | output | 1 | Surge interrupt flag |

## Verification
Register writes and interrupt clears show on the first rising edge after the strobe. A trip shows on edge 3 in the immediate path and on edge 3+N in the delayed path, counted from the edge after `cmpIn` changes. While the pin is in pulse mode, `pinOut` follows `pulseIn` in the same cycle. The bench drives every input on the falling clock edge and checks on the following falling edges. It checks the trip-enable bit after every single edge up to the expected one, for each delay value from 0 to 15, so a trip that arrives one edge early or one edge late is reported. The pin level it expects after a trip is the `pulseIn` value sampled on the falling edge just before the trip edge.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;

  // Bit positions of the enable bits inside wrData
  localparam int ARM_IDX     = 0;
  localparam int PULSE_IDX   = 1;
  localparam int TIMER_IDX   = 2;
  localparam int PARTNER_IDX = 3;
  localparam int EN_W        = 4;

  typedef struct packed {
    logic partnerArm;
    logic timerEn;
    logic pulseEn;
    logic arm;
  } enBits_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic trip;
    logic startDelay;
    logic cancelDelay;
  } dpStrobe_t;

endpackage

// File: rtl/trip_datapath.sv
module trip_datapath
  import pwm_trip_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpIn,
  input  logic             pulseIn,
  input  logic             pulseEn,
  input  logic [DLY_W-1:0] delayLoad,
  input  dpStrobe_t        strobe,
  output logic             fallDet,
  output logic             delayDone,
  output logic             delayBusy,
  output logic             pinOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   cmpSync;
  logic                   cmpPrev;
  logic [DLY_W-1:0]       dlyCnt;
  logic                   dlyPending;
  logic                   heldLevel;

  // Synchronizer: depth picked by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= cmpIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], cmpIn};
      end
    end
  endgenerate

  assign cmpSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmpPrev <= 1'b0;
    else       cmpPrev <= cmpSync;
  end

  assign fallDet = cmpPrev & ~cmpSync;

  // Trip delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyPending <= 1'b0;
      dlyCnt     <= '0;
    end else if (strobe.cancelDelay) begin
      dlyPending <= 1'b0;
    end else if (strobe.startDelay) begin
      dlyPending <= 1'b1;
      dlyCnt     <= delayLoad - 1'b1;
    end else if (dlyPending && (dlyCnt != '0)) begin
      dlyCnt <= dlyCnt - 1'b1;
    end
  end

  assign delayBusy = dlyPending;
  assign delayDone = dlyPending && (dlyCnt == '0);

  // Pin level keeper: tracks the pulse while in pulse mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        heldLevel <= 1'b0;
    else if (pulseEn) heldLevel <= pulseIn;
  end

  assign pinOut = pulseEn ? pulseIn : heldLevel;

endmodule

// File: rtl/trip_control.sv
module trip_control
  import pwm_trip_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [EN_W-1:0]  wrData,
  input  logic             irqClr,
  input  logic             delaySel,
  input  logic [DLY_W-1:0] delayLoad,
  input  logic             fallDet,
  input  logic             delayDone,
  input  logic             delayBusy,
  output enBits_t          enQ,
  output logic             irqQ,
  output dpStrobe_t        strobe
);

  logic armed;
  logic zeroLoad;
  logic tripNow;
  logic directPath;

  assign armed      = enQ.arm;
  assign zeroLoad   = (delayLoad == '0);
  assign directPath = ~delaySel | zeroLoad;
  assign tripNow    = armed & ((fallDet & directPath) | delayDone);

  always_comb begin
    strobe             = '0;
    strobe.trip        = tripNow;
    strobe.startDelay  = armed & fallDet & ~directPath & ~delayBusy;
    strobe.cancelDelay = ~armed | tripNow;
  end

  // Enable bits: trip clear wins over a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= '0;
    end else if (tripNow) begin
      enQ <= '0;
    end else if (wrEn) begin
      enQ.arm        <= wrData[ARM_IDX];
      enQ.pulseEn    <= wrData[PULSE_IDX];
      enQ.timerEn    <= wrData[TIMER_IDX];
      enQ.partnerArm <= wrData[PARTNER_IDX];
    end
  end

  // Surge flag: set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        irqQ <= 1'b0;
    else if (tripNow) irqQ <= 1'b1;
    else if (irqClr)  irqQ <= 1'b0;
  end

endmodule

// File: rtl/pwm_trip_ctrl.sv
module pwm_trip_ctrl
  import pwm_trip_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpIn,
  input  logic             wrEn,
  input  logic [3:0]       wrData,
  input  logic             irqClr,
  input  logic             delaySel,
  input  logic [DLY_W-1:0] delayLoad,
  input  logic             pulseIn,
  output logic             pinOut,
  output logic             pinIsPulse,
  output logic             armOut,
  output logic             pulseEnOut,
  output logic             timerEnOut,
  output logic             partnerArmOut,
  output logic             irq
);

  enBits_t   enQ;
  dpStrobe_t strobe;
  logic      fallDet;
  logic      delayDone;
  logic      delayBusy;

  trip_control #(.DLY_W(DLY_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .irqClr    (irqClr),
    .delaySel  (delaySel),
    .delayLoad (delayLoad),
    .fallDet   (fallDet),
    .delayDone (delayDone),
    .delayBusy (delayBusy),
    .enQ       (enQ),
    .irqQ      (irq),
    .strobe    (strobe)
  );

  trip_datapath #(.SYNC_STAGES(SYNC_STAGES), .DLY_W(DLY_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmpIn     (cmpIn),
    .pulseIn   (pulseIn),
    .pulseEn   (enQ.pulseEn),
    .delayLoad (delayLoad),
    .strobe    (strobe),
    .fallDet   (fallDet),
    .delayDone (delayDone),
    .delayBusy (delayBusy),
    .pinOut    (pinOut)
  );

  assign pinIsPulse    = enQ.pulseEn;
  assign armOut        = enQ.arm;
  assign pulseEnOut    = enQ.pulseEn;
  assign timerEnOut    = enQ.timerEn;
  assign partnerArmOut = enQ.partnerArm;

endmodule

// File: rtl/pwm_trip_ctrl_chk.sv
module pwm_trip_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic irqClr,
  input logic pulseIn,
  input logic pinOut,
  input logic pinIsPulse,
  input logic armOut,
  input logic pulseEnOut,
  input logic timerEnOut,
  input logic partnerArmOut,
  input logic irq
);

  // R5
  trip_clears_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (!armOut && !pulseEnOut && !timerEnOut && !partnerArmOut));

  // R3
  disarmed_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(armOut) && !$past(irq)) |-> !irq);

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irq) && !$past(irqClr)) |-> irq);

  // R6
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pinIsPulse && !$past(pinIsPulse)) |-> $stable(pinOut));

  // R6
  pin_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinIsPulse) |-> (pinOut == $past(pulseIn)));

  // R2
  pulse_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinIsPulse |-> (pinOut == pulseIn));

endmodule

bind pwm_trip_ctrl pwm_trip_ctrl_chk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .irqClr        (irqClr),
  .pulseIn       (pulseIn),
  .pinOut        (pinOut),
  .pinIsPulse    (pinIsPulse),
  .armOut        (armOut),
  .pulseEnOut    (pulseEnOut),
  .timerEnOut    (timerEnOut),
  .partnerArmOut (partnerArmOut),
  .irq           (irq)
);

// File: tb/pwm_trip_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm_trip_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmpIn = 1'b1;
  logic       wrEn = 1'b0;
  logic [3:0] wrData = '0;
  logic       irqClr = 1'b0;
  logic       delaySel = 1'b0;
  logic [3:0] delayLoad = '0;
  logic       pulseIn;
  logic       pinOut, pinIsPulse, armOut, pulseEnOut, timerEnOut, partnerArmOut, irq;

  logic       idleHigh = 1'b0;
  logic [2:0] genCnt = '0;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  // Stand-in pulse generator: idles when its timer enable is low
  always_ff @(posedge clk) genCnt <= genCnt + 3'd1;
  assign pulseIn = timerEnOut ? (genCnt[1] ^ idleHigh) : idleHigh;

  pwm_trip_ctrl dut_i (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .wrEn(wrEn), .wrData(wrData),
    .irqClr(irqClr), .delaySel(delaySel), .delayLoad(delayLoad), .pulseIn(pulseIn),
    .pinOut(pinOut), .pinIsPulse(pinIsPulse), .armOut(armOut), .pulseEnOut(pulseEnOut),
    .timerEnOut(timerEnOut), .partnerArmOut(partnerArmOut), .irq(irq)
  );

  function automatic logic [3:0] enVec();
    return {partnerArmOut, timerEnOut, pulseEnOut, armOut};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doWrite(logic [3:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic clearIrq();
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Arm everything, drop cmpIn, check arm after every edge up to lat
  task automatic runTrip(logic sel, logic [3:0] load, int lat, string req);
    logic expPin;
    delaySel = sel; delayLoad = load;
    expPin = 1'b0;
    doWrite(4'hF);
    @(negedge clk); cmpIn = 1'b0;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k == lat - 1) expPin = pulseIn;
      check(req, {7'd0, armOut}, {7'd0, (k < lat)});
    end
    check("R5 all bits cleared", {4'd0, enVec()}, 8'h00);
    check("R7 irq set", {7'd0, irq}, 8'h01);
    check("R6 gpio mode", {7'd0, pinIsPulse}, 8'h00);
    check("R6 pin level", {7'd0, pinOut}, {7'd0, expPin});
    idle(5);
    check("R6 pin held", {7'd0, pinOut}, {7'd0, expPin});
    clearIrq();
    check("R7 irq cleared", {7'd0, irq}, 8'h00);
    cmpIn = 1'b1;
    idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 enables", {4'd0, enVec()}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 mode", {7'd0, pinIsPulse}, 8'h00);
    check("R1 pin", {7'd0, pinOut}, 8'h00);

    // R2 writes and pass-through
    doWrite(4'b1010);
    check("R2 write 1010", {4'd0, enVec()}, 8'h0A);
    check("R2 mode", {7'd0, pinIsPulse}, 8'h01);
    doWrite(4'b0110);
    check("R2 write 0110", {4'd0, enVec()}, 8'h06);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R2 pin follows pulse", {7'd0, pinOut}, {7'd0, pulseIn});
    end
    doWrite(4'b0101);
    check("R2 write 0101", {4'd0, enVec()}, 8'h05);
    check("R2 mode off", {7'd0, pinIsPulse}, 8'h00);

    // R3 disarmed fall is ignored
    doWrite(4'b1110);
    @(negedge clk); cmpIn = 1'b0;
    idle(8);
    check("R3 enables unchanged", {4'd0, enVec()}, 8'h0E);
    check("R3 no irq", {7'd0, irq}, 8'h00);

    // R4 rising edge does not trip
    doWrite(4'hF);
    @(negedge clk); cmpIn = 1'b1;
    idle(8);
    check("R4 rise no trip", {4'd0, enVec()}, 8'h0F);
    check("R4 rise no irq", {7'd0, irq}, 8'h00);

    // R4 immediate path, both idle polarities, load ignored
    idleHigh = 1'b0; runTrip(1'b0, 4'd0, 3, "R4 immediate");
    idleHigh = 1'b1; runTrip(1'b0, 4'd0, 3, "R4 immediate idle-high");
    idleHigh = 1'b0; runTrip(1'b0, 4'd7, 3, "R4 load ignored");

    // R8 delayed sweep
    for (int n = 0; n < 16; n++) begin
      idleHigh = n[0];
      runTrip(1'b1, n[3:0], 3 + n, "R8 delayed");
    end

    // R5 / R7 write and clear collide with trip
    delaySel = 1'b0;
    doWrite(4'hF);
    @(negedge clk); cmpIn = 1'b0;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; wrData = 4'hF; irqClr = 1'b1;
    @(negedge clk); wrEn = 1'b0; irqClr = 1'b0;
    check("R5 trip beats write", {4'd0, enVec()}, 8'h00);
    check("R7 trip beats clear", {7'd0, irq}, 8'h01);
    cmpIn = 1'b1; idle(4);

    // R7 second trip while flag set
    runTripKeep();

    // R8 cancel by disarm
    delaySel = 1'b1; delayLoad = 4'd8;
    doWrite(4'hF);
    @(negedge clk); cmpIn = 1'b0;
    idle(3);
    doWrite(4'b1110);
    idle(14);
    check("R8 cancelled enables", {4'd0, enVec()}, 8'h0E);
    check("R8 cancelled irq", {7'd0, irq}, 8'h00);
    cmpIn = 1'b1; idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic runTripKeep();
    doWrite(4'hF);
    @(negedge clk); cmpIn = 1'b0;
    idle(3);
    check("R7 flag kept on second trip", {7'd0, irq}, 8'h01);
    check("R5 second trip clears", {4'd0, enVec()}, 8'h00);
    clearIrq();
    check("R7 cleared after second trip", {7'd0, irq}, 8'h00);
    cmpIn = 1'b1; idle(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule